// File: doc/BRIEF.md
# Memory-Card SPI Command Engine

This block issues a single command to a memory card operating in SPI mode and hands back the card's one-byte R1 reply. It works at byte level: it drives a byte-exchange SPI master (one byte out, one byte back, a completion strobe) and owns the card's active-low chip select. A caller presents a 6-bit command index, a 32-bit argument and a flag that marks an application-specific command, then pulses `start`.

For each command frame the engine first releases the card and clocks one idle byte. It then selects the card and polls until the card reports ready. It sends the six-byte frame, optionally discards one filler byte, and polls for a reply whose top bit is clear. Application commands are preceded automatically by the application-prefix command (index 55). The engine stops early if that prefix is refused. A card that never becomes ready ends the command with a reply of 0xFF and a raised timeout flag.

The chip select stays asserted after a normal completion, so a caller can go straight into a data phase. The next command always starts by releasing the card.

Top module: `sd_cmd_engine`

## Requirements
- R1: A frame is six bytes sent with `csN` low: first `0x40 | cmdIdx` (bits 7:6 = 01, bits 5:0 = index), then the argument bytes from bits 31:24 down to bits 7:0.
- R2: The sixth frame byte is 0x95 when the index is 0, 0x87 when the index is 8, and 0x01 for any other index.
- R3: Before every frame the engine exchanges one byte with `csN` high, then drives `csN` low and keeps exchanging bytes until a received byte equals 0xFF. Only then does the frame start.
- R4: With `appCmd` set, a frame with index 55 and a zero argument goes first. If its reply is greater than 0x01, the command ends with that reply. Otherwise the requested frame follows, with its own pre-frame sequence (R3).
- R5: After a frame with index 12, one extra byte is exchanged and its received value is discarded, whatever it is.
- R6: Reply polling exchanges at most `RESP_TRIES` (10) bytes and stops at the first received byte with bit 7 = 0. The reported reply is that byte, or the last polled byte if none qualifies.
- R7: If `READY_LIMIT` ready polls all return something other than 0xFF, the engine drives `csN` high, exchanges one byte, and ends with reply 0xFF and `timeout` = 1.
- R8: Every exchanged byte that is not a frame byte transmits 0xFF. `spiStart` is a one-cycle pulse, and the next one comes only after `spiDone` for the previous byte.
- R9: `done` is high for exactly one cycle, the cycle after the final `spiDone`. `respByte` and `timeout` then hold until the next accepted start. `timeout` is 0 after a command that did not time out.
- R10: A `start` pulse while a command is in progress is ignored, and the inputs are sampled only when a start is accepted.
- R11: After reset `csN` = 1, `done` = 0, `timeout` = 0, `spiStart` = 0 and `respByte` = 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| cmdIdx | input | 6 | Command index |
| appCmd | input | 1 | Prefix the command with index 55 |
| cmdArg | input | 32 | Command argument |
| spiStart | output | 1 | Request one byte exchange |
| spiTxByte | output | 8 | Byte to transmit |
| spiRxByte | input | 8 | Byte received, valid with spiDone |
| spiDone | input | 1 | Byte exchange finished |
| csN | output | 1 | Card chip select, active low |
| respByte | output | 8 | Reply byte of the last command |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Last command ended on ready timeout |

## Verification
The hardest situations to reach from the ports are the reply-poll bound and the discarded filler byte. The first needs a card that answers ten times with bit 7 set. The second needs a filler byte that would itself look like a valid reply. The bench models the card as a scripted queue of replies, one per exchange, and puts a plausible value (0x7F) into the filler slot. It also puts a distinctive non-0xFF byte into the tenth poll slot, so any miscount shows up either as a wrong reply or as an exchange the script did not expect. Prefix refusal and ready timeout inside the prefix are reached the same way, by scripting the card's replies for the prefix frame.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_DESEL, S_RDY, S_FRAME, S_STUFF, S_RESP, S_TOUT
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic useMain;
    logic csAssert;
    logic csRelease;
    logic cntClr;
    logic cntInc;
    logic txFrame;
    logic respCap;
    logic toutSet;
  } dpCtl_t;

  localparam logic [5:0] IDX_RESET  = 6'd0;
  localparam logic [5:0] IDX_IFCOND = 6'd8;
  localparam logic [5:0] IDX_STOP   = 6'd12;
  localparam logic [5:0] IDX_APP    = 6'd55;
  localparam logic [7:0] CRC_RESET  = 8'h95;
  localparam logic [7:0] CRC_IFCOND = 8'h87;
  localparam logic [7:0] CRC_OTHER  = 8'h01;
  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
  localparam int         FRAME_LEN  = 6;

endpackage

// File: rtl/sd_cmd_dp.sv
module sd_cmd_dp
  import sd_cmd_pkg::*;
#(
  parameter int READY_LIMIT = 5000,
  parameter int RESP_TRIES  = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [5:0]  cmdIdx,
  input  logic        appCmd,
  input  logic [31:0] cmdArg,
  input  logic [7:0]  spiRxByte,
  output logic [7:0]  txByte,
  output logic        csN,
  output logic [7:0]  respByte,
  output logic        timeout,
  output logic        frameEnd,
  output logic        pollEnd,
  output logic        readyEnd,
  output logic        isStop,
  output logic        isPrefix
);

  localparam int CNT_A   = (READY_LIMIT > RESP_TRIES) ? READY_LIMIT : RESP_TRIES;
  localparam int CNT_TOP = (CNT_A > FRAME_LEN) ? CNT_A : FRAME_LEN;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  logic [5:0]       idxQ;
  logic [31:0]      argQ;
  logic             mainQ;
  logic [CNT_W-1:0] cntQ;
  logic [7:0]       respQ;
  logic             toutQ;
  logic             csNQ;

  logic [5:0]  curIdx;
  logic [31:0] curArg;
  logic [7:0]  crcByte;
  logic [7:0]  frameByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      argQ  <= '0;
      mainQ <= 1'b1;
      cntQ  <= '0;
      respQ <= IDLE_BYTE;
      toutQ <= 1'b0;
      csNQ  <= 1'b1;
    end else begin
      if (ctl.load) begin
        idxQ  <= cmdIdx;
        argQ  <= cmdArg;
        mainQ <= !appCmd;
        toutQ <= 1'b0;
      end
      if (ctl.useMain) mainQ <= 1'b1;
      if (ctl.cntClr) cntQ <= '0;
      else if (ctl.cntInc) cntQ <= cntQ + 1'b1;
      if (ctl.csAssert) csNQ <= 1'b0;
      else if (ctl.csRelease) csNQ <= 1'b1;
      if (ctl.toutSet) begin
        toutQ <= 1'b1;
        respQ <= IDLE_BYTE;
      end else if (ctl.respCap) begin
        respQ <= spiRxByte;
      end
    end
  end

  assign curIdx = mainQ ? idxQ : IDX_APP;
  assign curArg = mainQ ? argQ : 32'd0;

  always_comb begin
    if (curIdx == IDX_RESET)       crcByte = CRC_RESET;
    else if (curIdx == IDX_IFCOND) crcByte = CRC_IFCOND;
    else                           crcByte = CRC_OTHER;
  end

  always_comb begin
    case (cntQ)
      CNT_W'(0): frameByte = {2'b01, curIdx};
      CNT_W'(1): frameByte = curArg[31:24];
      CNT_W'(2): frameByte = curArg[23:16];
      CNT_W'(3): frameByte = curArg[15:8];
      CNT_W'(4): frameByte = curArg[7:0];
      default:   frameByte = crcByte;
    endcase
  end

  assign txByte   = ctl.txFrame ? frameByte : IDLE_BYTE;
  assign csN      = csNQ;
  assign respByte = respQ;
  assign timeout  = toutQ;
  assign frameEnd = (cntQ == CNT_W'(FRAME_LEN - 1));
  assign pollEnd  = (cntQ == CNT_W'(RESP_TRIES - 1));
  assign readyEnd = (cntQ == CNT_W'(READY_LIMIT - 1));
  assign isStop   = (curIdx == IDX_STOP);
  assign isPrefix = !mainQ;

  // R1: frame bytes only go out while the card is selected
  assert_frame_selected_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.txFrame |-> !csNQ);

endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       spiDone,
  input  logic [7:0] spiRxByte,
  input  logic       frameEnd,
  input  logic       pollEnd,
  input  logic       readyEnd,
  input  logic       isStop,
  input  logic       isPrefix,
  output dpCtl_t     ctl,
  output logic       spiStart,
  output logic       done
);

  engState_t stateQ, stateNext;
  logic      busyQ;
  logic      doneQ, doneNext;
  logic      byteDone;

  assign byteDone = busyQ && spiDone;
  assign spiStart = (stateQ != S_IDLE) && !busyQ;
  assign done     = doneQ;

  always_comb begin
    ctl       = '0;
    stateNext = stateQ;
    doneNext  = 1'b0;
    case (stateQ)
      S_IDLE: if (start) begin
        ctl.load = 1'b1; ctl.csRelease = 1'b1; ctl.cntClr = 1'b1;
        stateNext = S_DESEL;
      end
      S_DESEL: if (byteDone) begin
        ctl.csAssert = 1'b1; ctl.cntClr = 1'b1;
        stateNext = S_RDY;
      end
      S_RDY: if (byteDone) begin
        if (spiRxByte == IDLE_BYTE) begin
          ctl.cntClr = 1'b1;
          stateNext  = S_FRAME;
        end else if (readyEnd) begin
          ctl.csRelease = 1'b1;
          stateNext     = S_TOUT;
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      S_FRAME: begin
        ctl.txFrame = 1'b1;
        if (byteDone) begin
          if (frameEnd) begin
            ctl.cntClr = 1'b1;
            stateNext  = isStop ? S_STUFF : S_RESP;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      S_STUFF: if (byteDone) stateNext = S_RESP;
      S_RESP: if (byteDone) begin
        if (!spiRxByte[7] || pollEnd) begin
          ctl.respCap = 1'b1;
          if (isPrefix && spiRxByte <= 8'd1) begin
            ctl.useMain = 1'b1; ctl.csRelease = 1'b1; ctl.cntClr = 1'b1;
            stateNext = S_DESEL;
          end else begin
            doneNext  = 1'b1;
            stateNext = S_IDLE;
          end
        end else begin
          ctl.cntInc = 1'b1;
        end
      end
      S_TOUT: if (byteDone) begin
        ctl.toutSet = 1'b1;
        doneNext    = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= doneNext;
      if (spiStart) busyQ <= 1'b1;
      else if (spiDone) busyQ <= 1'b0;
    end
  end

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: one byte in flight at a time
  assert_single_flight_R8: assert property (@(posedge clk) disable iff (!rstN)
    spiStart |=> !spiStart);

  // R6: a reply with bit 7 clear ends a main command at once
  assert_poll_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_RESP && byteDone && !spiRxByte[7] && !isPrefix) |=> done);

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int READY_LIMIT = 5000,
  parameter int RESP_TRIES  = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [5:0]  cmdIdx,
  input  logic        appCmd,
  input  logic [31:0] cmdArg,
  output logic        spiStart,
  output logic [7:0]  spiTxByte,
  input  logic [7:0]  spiRxByte,
  input  logic        spiDone,
  output logic        csN,
  output logic [7:0]  respByte,
  output logic        done,
  output logic        timeout
);

  dpCtl_t ctl;
  logic   frameEnd, pollEnd, readyEnd, isStop, isPrefix;

  sd_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .spiDone(spiDone),
    .spiRxByte(spiRxByte), .frameEnd(frameEnd), .pollEnd(pollEnd),
    .readyEnd(readyEnd), .isStop(isStop), .isPrefix(isPrefix),
    .ctl(ctl), .spiStart(spiStart), .done(done)
  );

  sd_cmd_dp #(.READY_LIMIT(READY_LIMIT), .RESP_TRIES(RESP_TRIES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdIdx(cmdIdx), .appCmd(appCmd),
    .cmdArg(cmdArg), .spiRxByte(spiRxByte), .txByte(spiTxByte), .csN(csN),
    .respByte(respByte), .timeout(timeout), .frameEnd(frameEnd),
    .pollEnd(pollEnd), .readyEnd(readyEnd), .isStop(isStop), .isPrefix(isPrefix)
  );

  // R7: a timed-out command finishes with the card released
  assert_tout_deselect_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && timeout) |-> csN);

endmodule

// File: tb/sd_cmd_engine_bench.sv
module sd_cmd_engine_bench;

  localparam int READY_LIM = 6;
  localparam int RESP_N    = 10;
  localparam int LAT       = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cmdIdx = '0;
  logic        appCmd = 1'b0;
  logic [31:0] cmdArg = '0;
  logic        spiStart;
  logic [7:0]  spiTxByte;
  logic [7:0]  spiRxByte = 8'hFF;
  logic        spiDone = 1'b0;
  logic        csN;
  logic [7:0]  respByte;
  logic        done;
  logic        timeout;

  always #5 clk = ~clk;

  sd_cmd_engine #(.READY_LIMIT(READY_LIM), .RESP_TRIES(RESP_N)) u_sd_cmd_engine (
    .clk(clk), .rstN(rstN), .start(start), .cmdIdx(cmdIdx), .appCmd(appCmd),
    .cmdArg(cmdArg), .spiStart(spiStart), .spiTxByte(spiTxByte),
    .spiRxByte(spiRxByte), .spiDone(spiDone), .csN(csN),
    .respByte(respByte), .done(done), .timeout(timeout)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // card model: one scripted entry per expected exchange
  logic [7:0] qTx[$];
  logic       qCs[$];
  logic [7:0] qRx[$];
  string      qTag[$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [7:0] tx, logic cs, logic [7:0] rx, string tag);
    qTx.push_back(tx); qCs.push_back(cs); qRx.push_back(rx); qTag.push_back(tag);
  endtask

  task automatic preFrame(int nBusy);
    push(8'hFF, 1'b1, 8'hFF, "R3");
    repeat (nBusy) push(8'hFF, 1'b0, 8'h00, "R3");
    push(8'hFF, 1'b0, 8'hFF, "R3");
  endtask

  task automatic frame(logic [5:0] idx, logic [31:0] arg);
    logic [7:0] crc;
    crc = (idx == 6'd0) ? 8'h95 : (idx == 6'd8) ? 8'h87 : 8'h01;
    push({2'b01, idx}, 1'b0, 8'hFF, "R1");
    for (int b = 3; b >= 0; b--) push(arg[8*b +: 8], 1'b0, 8'hFF, "R1");
    push(crc, 1'b0, 8'hFF, "R2");
  endtask

  task automatic respSeq(int nBad, logic [7:0] val);
    repeat (nBad) push(8'hFF, 1'b0, 8'hFF, "R6");
    push(8'hFF, 1'b0, val, "R6");
  endtask

  task automatic timeoutSeq();
    push(8'hFF, 1'b1, 8'hFF, "R3");
    repeat (READY_LIM) push(8'hFF, 1'b0, 8'h00, "R7");
    push(8'hFF, 1'b1, 8'hFF, "R7");
  endtask

  // byte-exchange slave, compared against the script on every clock
  initial begin
    int pend;
    logic [7:0] cur;
    pend = 0;
    cur  = 8'hFF;
    forever begin
      @(negedge clk);
      spiDone = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          spiDone   = 1'b1;
          spiRxByte = cur;
        end
      end
      if (spiStart) begin
        if (pend != 0) check(1'b0, "R8", "start while byte in flight", 1, 0);
        if (qTx.size() == 0) begin
          check(1'b0, "R8", "unexpected exchange", spiTxByte, 0);
          cur = 8'hFF;
        end else begin
          logic [7:0] t;
          logic c;
          string tg;
          t = qTx.pop_front(); c = qCs.pop_front(); tg = qTag.pop_front();
          cur = qRx.pop_front();
          check(spiTxByte == t, tg, "tx byte", spiTxByte, t);
          check(csN == c, tg, "chip select", csN, c);
        end
        pend = LAT;
      end
    end
  end

  task automatic runCmd(logic [5:0] idx, logic app, logic [31:0] arg,
                        logic [7:0] expResp, logic expTout, string tag, bit glitch);
    bit got;
    @(negedge clk);
    cmdIdx = idx; appCmd = app; cmdArg = arg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    for (int n = 0; n < 3000; n++) begin
      if (done) begin got = 1; break; end
      if (glitch && n == 4) begin
        start = 1'b1; cmdIdx = 6'd7; cmdArg = ~arg; appCmd = ~app;  // R10
      end
      if (glitch && n == 5) start = 1'b0;
      @(negedge clk);
    end
    check(got, "R9", {tag, " done seen"}, got, 1);
    check(respByte == expResp, tag, "reply byte", respByte, expResp);
    check(timeout == expTout, tag, "timeout flag", timeout, expTout);
    check(qTx.size() == 0, tag, "script consumed", qTx.size(), 0);
    @(negedge clk);
    check(!done, "R9", "done lasts one cycle", done, 0);
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(csN == 1'b1, "R11", "csN after reset", csN, 1);
    check(!done, "R11", "done after reset", done, 0);
    check(!timeout, "R11", "timeout after reset", timeout, 0);
    check(!spiStart, "R11", "spiStart after reset", spiStart, 0);
    check(respByte == 8'hFF, "R11", "reply after reset", respByte, 8'hFF);

    // R1 R2 R3 R6: index 0, ready at once, one busy reply
    preFrame(0); frame(6'd0, 32'd0); respSeq(1, 8'h01);
    runCmd(6'd0, 1'b0, 32'd0, 8'h01, 1'b0, "R2", 1'b0);

    // R2 R3: index 8 with a busy card
    preFrame(3); frame(6'd8, 32'h0000_01AA); respSeq(0, 8'h01);
    runCmd(6'd8, 1'b0, 32'h0000_01AA, 8'h01, 1'b0, "R2", 1'b0);

    // R6: ten polls, none qualifies, last byte reported
    preFrame(1); frame(6'd17, 32'h1234_5678);
    repeat (RESP_N - 1) push(8'hFF, 1'b0, 8'hFF, "R6");
    push(8'hFF, 1'b0, 8'h9A, "R6");
    runCmd(6'd17, 1'b0, 32'h1234_5678, 8'h9A, 1'b0, "R6", 1'b0);

    // R5: filler byte after index 12 looks valid but must be skipped
    preFrame(0); frame(6'd12, 32'd0);
    push(8'hFF, 1'b0, 8'h7F, "R5");
    respSeq(2, 8'h00);
    runCmd(6'd12, 1'b0, 32'd0, 8'h00, 1'b0, "R5", 1'b0);

    // R4: prefix accepted, main command follows
    preFrame(0); frame(6'd55, 32'd0); respSeq(0, 8'h01);
    preFrame(2); frame(6'd41, 32'h4000_0000); respSeq(1, 8'h00);
    runCmd(6'd41, 1'b1, 32'h4000_0000, 8'h00, 1'b0, "R4", 1'b0);

    // R4: prefix refused, stop with its reply
    preFrame(0); frame(6'd55, 32'd0); respSeq(0, 8'h05);
    runCmd(6'd23, 1'b1, 32'h0000_0008, 8'h05, 1'b0, "R4", 1'b0);

    // R7: ready timeout
    timeoutSeq();
    runCmd(6'd24, 1'b0, 32'h0000_0200, 8'hFF, 1'b1, "R7", 1'b0);

    // R9 R10: timeout flag clears, start mid-run ignored
    preFrame(0); frame(6'd24, 32'h0000_0200); respSeq(0, 8'h00);
    runCmd(6'd24, 1'b0, 32'h0000_0200, 8'h00, 1'b0, "R10", 1'b1);

    // R9: outputs hold while inputs move without a start
    held = respByte;
    cmdIdx = 6'd3; cmdArg = 32'hDEAD_BEEF; appCmd = 1'b1;
    repeat (5) @(negedge clk);
    check(respByte == held, "R9", "reply holds", respByte, held);
    check(!timeout, "R9", "timeout holds", timeout, 0);

    // R4 R7: prefix itself times out
    timeoutSeq();
    runCmd(6'd41, 1'b1, 32'd0, 8'hFF, 1'b1, "R7", 1'b0);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule